// File: doc/BRIEF.md
# Serial Clock Divisor Search Engine

This block picks the settings for a two-stage serial clock divider. The first stage is an even prescaler. The second stage is a rate field: a counter that divides by one more than its value. Given the frequency of the clock that feeds the divider and a requested serial clock frequency, the engine finds the pair whose resulting frequency lies closest to the request. It reports that pair and the frequency it actually yields.

A request is launched with a one-cycle `start_i` pulse. The engine first works out the fastest and slowest frequencies the divider can reach. If the request falls outside that range, it flags an error and skips the search. Otherwise it tries the pairs one at a time, in a fixed order, using a shared iterative divider, and keeps the best candidate found so far. It stops as soon as a candidate hits the request exactly. A one-cycle `done_o` pulse presents the result. The result outputs then hold until the next result is produced.

Top module: `sdiv_search`

## Requirements
- R1: Each candidate frequency is the truncated integer quotient `in_rate / (cpsr * (1 + scr))`, computed by a restoring divider that produces one quotient bit per cycle.
- R2: If the request is above `in_rate / CPSR_MIN` or below `in_rate / (CPSR_MAX * (SCR_MAX + 1))`, the engine performs no search and reports `err_o = 1`, `cpsr_o = CPSR_MIN`, `scr_o = 0` and `freq_o = 0`.
- R3: Pairs are tried with the prescaler as the outer loop, running over even values from `CPSR_MIN` to `CPSR_MAX`. The rate field is the inner loop, running from 0 to `SCR_MAX` and restarting at 0 for each new prescaler value.
- R4: A candidate becomes the new best only if its absolute distance to the request is strictly smaller than that of the current best. On a tie, the earlier pair is kept. The search begins with best frequency 0 and best pair (`CPSR_MIN`, 0).
- R5: A candidate equal to the request ends the search at once.
- R6: After a search, `err_o = 0` and the outputs give the best pair and its frequency.
- R7: `done_o` is high for exactly one cycle per accepted request. `err_o`, `cpsr_o`, `scr_o` and `freq_o` change only in a cycle where `done_o` is high, and hold their values otherwise.
- R8: `start_i` is ignored while a request is in progress. Such a pulse changes no result and produces no extra `done_o`.
- R9: After reset, `done_o = 0`, `err_o = 0`, `cpsr_o = CPSR_MIN`, `scr_o = 0` and `freq_o = 0`.
- R10: A reported prescaler is always even and within `CPSR_MIN..CPSR_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a search (one-cycle pulse, honoured only when idle) |
| in_rate_i | input | RATE_W | Frequency of the clock feeding the divider |
| req_rate_i | input | RATE_W | Requested serial clock frequency |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Request outside the reachable range |
| cpsr_o | output | CPSR_W | Chosen even prescaler |
| scr_o | output | SCR_W | Chosen rate field value |
| freq_o | output | RATE_W | Frequency produced by the chosen pair |

## Verification
Some properties are checked on every cycle. Every divider result must bracket the dividend correctly as a truncated quotient. `done_o` must stay a single-cycle strobe, and the result outputs must be stable between strobes. A rejected request must carry the fixed fallback values. A reported prescaler must be even and in range. A reported frequency must never exceed what its pair produces. The best-so-far distance must never grow during a search. Other behaviour depends on the request and only the bench's scenarios can show it: which pair wins, whether ties keep the earlier pair, whether an exact hit actually shortens the run, and whether a start pulse during a search is dropped. The bench compares results against a behavioural model of the search order.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MAXW  = 3'd1,
        ST_MINW  = 3'd2,
        ST_CANDW = 3'd3,
        ST_FIN   = 3'd4
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_divider.sv
module sdiv_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_t;

    div_t q, d;

    always_comb begin
        logic [W:0] sh;
        logic [W:0] sub;
        d      = q;
        d.done = 1'b0;
        sh     = '0;
        sub    = '0;
        if (!q.busy) begin
            if (go_i) begin
                d.rem  = '0;
                d.quo  = num_i;
                d.cnt  = CW'(W);
                d.busy = 1'b1;
            end
        end else begin
            sh    = {q.rem, q.quo[W-1]};
            d.quo = {q.quo[W-2:0], 1'b0};
            if (sh >= {1'b0, den_i}) begin
                sub      = sh - {1'b0, den_i};
                d.rem    = sub[W-1:0];
                d.quo[0] = 1'b1;
            end else begin
                d.rem = sh[W-1:0];
            end
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;
endmodule

// File: rtl/sdiv_best.sv
module sdiv_best #(
    parameter int RATE_W   = 32,
    parameter int CPSR_W   = 8,
    parameter int SCR_W    = 8,
    parameter int CPSR_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [RATE_W-1:0] target_i,
    input  logic              cand_vld_i,
    input  logic [RATE_W-1:0] cand_freq_i,
    input  logic [CPSR_W-1:0] cand_cpsr_i,
    input  logic [SCR_W-1:0]  cand_scr_i,
    output logic              exact_o,
    output logic [RATE_W-1:0] best_freq_o,
    output logic [CPSR_W-1:0] best_cpsr_o,
    output logic [SCR_W-1:0]  best_scr_o
);
    typedef struct packed {
        logic [RATE_W-1:0] freq;
        logic [CPSR_W-1:0] cpsr;
        logic [SCR_W-1:0]  scr;
    } best_t;

    best_t q, d;
    logic [RATE_W-1:0] dist_new, dist_best;

    function automatic logic [RATE_W-1:0] gap(input logic [RATE_W-1:0] a,
                                              input logic [RATE_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    always_comb begin
        dist_new  = gap(target_i, cand_freq_i);
        dist_best = gap(target_i, q.freq);
        exact_o   = cand_vld_i && (cand_freq_i == target_i);
        d         = q;
        if (clr_i) begin
            d.freq = '0;
            d.cpsr = CPSR_W'(CPSR_MIN);
            d.scr  = '0;
        end else if (cand_vld_i && (dist_new < dist_best)) begin
            d.freq = cand_freq_i;
            d.cpsr = cand_cpsr_i;
            d.scr  = cand_scr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cpsr <= CPSR_W'(CPSR_MIN);
        end else begin
            q <= d;
        end
    end

    assign best_freq_o = q.freq;
    assign best_cpsr_o = q.cpsr;
    assign best_scr_o  = q.scr;

    // The distance of the kept best never grows while a search runs.
    assert_best_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> dist_best <= $past(dist_best));
endmodule

// File: rtl/sdiv_search.sv
module sdiv_search #(
    parameter int RATE_W   = 32,
    parameter int CPSR_W   = 8,
    parameter int SCR_W    = 8,
    parameter int CPSR_MIN = 2,
    parameter int CPSR_MAX = 254,
    parameter int SCR_MAX  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] in_rate_i,
    input  logic [RATE_W-1:0] req_rate_i,
    output logic              done_o,
    output logic              err_o,
    output logic [CPSR_W-1:0] cpsr_o,
    output logic [SCR_W-1:0]  scr_o,
    output logic [RATE_W-1:0] freq_o
);
    import sdiv_pkg::*;

    localparam int DEN_W = CPSR_W + SCR_W + 1;
    localparam int W2    = 2 * RATE_W;

    typedef struct packed {
        sdiv_state_e       st;
        logic [RATE_W-1:0] rate;
        logic [RATE_W-1:0] target;
        logic [RATE_W-1:0] maxf;
        logic [RATE_W-1:0] den;
        logic [CPSR_W-1:0] cpsr;
        logic [SCR_W-1:0]  scr;
        logic              go;
        logic              done;
        logic              err;
        logic [CPSR_W-1:0] cpsr_out;
        logic [SCR_W-1:0]  scr_out;
        logic [RATE_W-1:0] freq_out;
    } ctl_t;

    ctl_t q, d;

    logic              div_done;
    logic [RATE_W-1:0] div_quo;
    logic              cand_vld, clr, exact;
    logic [RATE_W-1:0] best_freq;
    logic [CPSR_W-1:0] best_cpsr;
    logic [SCR_W-1:0]  best_scr;

    function automatic logic [RATE_W-1:0] den_of(input logic [CPSR_W-1:0] c,
                                                 input logic [SCR_W-1:0]  s);
        logic [DEN_W-1:0] p;
        p = DEN_W'(c) * (DEN_W'(s) + DEN_W'(1));
        return RATE_W'(p);
    endfunction

    sdiv_divider #(.W(RATE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (q.go),
        .num_i  (q.rate),
        .den_i  (q.den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    assign cand_vld = (q.st == ST_CANDW) && div_done;
    assign clr      = (q.st == ST_IDLE) && start_i;

    sdiv_best #(
        .RATE_W   (RATE_W),
        .CPSR_W   (CPSR_W),
        .SCR_W    (SCR_W),
        .CPSR_MIN (CPSR_MIN)
    ) u_best (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .target_i    (q.target),
        .cand_vld_i  (cand_vld),
        .cand_freq_i (div_quo),
        .cand_cpsr_i (q.cpsr),
        .cand_scr_i  (q.scr),
        .exact_o     (exact),
        .best_freq_o (best_freq),
        .best_cpsr_o (best_cpsr),
        .best_scr_o  (best_scr)
    );

    always_comb begin
        logic [CPSR_W:0] nc;
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        nc     = {1'b0, q.cpsr} + (CPSR_W+1)'(2);
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.rate   = in_rate_i;
                    d.target = req_rate_i;
                    d.den    = den_of(CPSR_W'(CPSR_MIN), '0);
                    d.go     = 1'b1;
                    d.st     = ST_MAXW;
                end
            end
            ST_MAXW: begin
                if (div_done) begin
                    d.maxf = div_quo;
                    d.den  = den_of(CPSR_W'(CPSR_MAX), SCR_W'(SCR_MAX));
                    d.go   = 1'b1;
                    d.st   = ST_MINW;
                end
            end
            ST_MINW: begin
                if (div_done) begin
                    if ((q.target > q.maxf) || (q.target < div_quo)) begin
                        d.err      = 1'b1;
                        d.cpsr_out = CPSR_W'(CPSR_MIN);
                        d.scr_out  = '0;
                        d.freq_out = '0;
                        d.done     = 1'b1;
                        d.st       = ST_IDLE;
                    end else begin
                        d.cpsr = CPSR_W'(CPSR_MIN);
                        d.scr  = '0;
                        d.den  = den_of(CPSR_W'(CPSR_MIN), '0);
                        d.go   = 1'b1;
                        d.st   = ST_CANDW;
                    end
                end
            end
            ST_CANDW: begin
                if (div_done) begin
                    if (exact) begin
                        d.st = ST_FIN;
                    end else if (q.scr == SCR_W'(SCR_MAX)) begin
                        if (nc > (CPSR_W+1)'(CPSR_MAX)) begin
                            d.st = ST_FIN;
                        end else begin
                            d.cpsr = nc[CPSR_W-1:0];
                            d.scr  = '0;
                            d.den  = den_of(nc[CPSR_W-1:0], '0);
                            d.go   = 1'b1;
                        end
                    end else begin
                        d.scr = q.scr + SCR_W'(1);
                        d.den = den_of(q.cpsr, q.scr + SCR_W'(1));
                        d.go  = 1'b1;
                    end
                end
            end
            ST_FIN: begin
                d.err      = 1'b0;
                d.cpsr_out = best_cpsr;
                d.scr_out  = best_scr;
                d.freq_out = best_freq;
                d.done     = 1'b1;
                d.st       = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.cpsr_out <= CPSR_W'(CPSR_MIN);
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign err_o  = q.err;
    assign cpsr_o = q.cpsr_out;
    assign scr_o  = q.scr_out;
    assign freq_o = q.freq_out;

    // Assertion-only products for quotient bracketing.
    logic [W2-1:0] qd_prod, out_prod;
    assign qd_prod  = W2'(div_quo) * W2'(q.den);
    assign out_prod = W2'(freq_o) * W2'(den_of(cpsr_o, scr_o));

    assert_quotient_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (qd_prod <= W2'(q.rate)) && (qd_prod + W2'(q.den) > W2'(q.rate)));

    assert_reject_values_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (cpsr_o == CPSR_W'(CPSR_MIN)) && (scr_o == '0) && (freq_o == '0));

    assert_result_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> out_prod <= W2'(q.rate));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({err_o, cpsr_o, scr_o, freq_o}));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start_i) |=> $stable({q.rate, q.target}));

    assert_cpsr_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cpsr_o[0] && (cpsr_o >= CPSR_W'(CPSR_MIN)) && (cpsr_o <= CPSR_W'(CPSR_MAX)));
endmodule

// File: tb/tb_sdiv_search.sv
`timescale 1ns/1ps
module tb_sdiv_search;
    localparam int RW   = 32;
    localparam int CW   = 8;
    localparam int SW   = 8;
    localparam int CMIN = 2;
    localparam int CMAX = 10;
    localparam int SMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [RW-1:0] in_rate = '0;
    logic [RW-1:0] req_rate = '0;
    logic          done, err;
    logic [CW-1:0] cpsr;
    logic [SW-1:0] scr;
    logic [RW-1:0] freq;

    always #4 clk = ~clk;

    sdiv_search #(
        .RATE_W(RW), .CPSR_W(CW), .SCR_W(SW),
        .CPSR_MIN(CMIN), .CPSR_MAX(CMAX), .SCR_MAX(SMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .in_rate_i(in_rate), .req_rate_i(req_rate),
        .done_o(done), .err_o(err), .cpsr_o(cpsr), .scr_o(scr), .freq_o(freq)
    );

    typedef struct {
        bit      err;
        int      cpsr;
        int      scr;
        longint  freq;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    bit    prev_done = 0;
    bit    last_err;
    int    last_cpsr, last_scr;
    longint last_freq;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input longint rate, input longint tgt);
        exp_t   r;
        longint mx, mn, bf, t, dn, db;
        int     bc, bs;
        bit     found;
        mx = rate / CMIN;
        mn = rate / (CMAX * (SMAX + 1));
        r.err = 0; r.cpsr = CMIN; r.scr = 0; r.freq = 0;
        if (tgt > mx || tgt < mn) begin
            r.err = 1;
            return r;
        end
        bf = 0; bc = CMIN; bs = 0; found = 0;
        for (int c = CMIN; c <= CMAX && !found; c += 2) begin
            for (int s = 0; s <= SMAX && !found; s++) begin
                t  = rate / (c * (s + 1));
                dn = (tgt > t) ? tgt - t : t - tgt;
                db = (tgt > bf) ? tgt - bf : bf - tgt;
                if (dn < db) begin
                    bf = t; bc = c; bs = s;
                    if (t == tgt) found = 1;
                end
            end
        end
        r.cpsr = bc; r.scr = bs; r.freq = bf;
        return r;
    endfunction

    // Monitor: samples 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (done && prev_done)
                check(0, "R7", "done longer than one cycle", 1, 0);
            if (done) begin
                last_err = err; last_cpsr = int'(cpsr); last_scr = int'(scr); last_freq = longint'(freq);
                if (expq.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t  e;
                    string tg;
                    e  = expq.pop_front();
                    tg = tagq.pop_front();
                    check(err == e.err, tg, "err", longint'(err), longint'(e.err));
                    check(int'(cpsr) == e.cpsr, tg, "cpsr", longint'(cpsr), longint'(e.cpsr));
                    check(int'(scr) == e.scr, tg, "scr", longint'(scr), longint'(e.scr));
                    check(longint'(freq) == e.freq, tg, "freq", longint'(freq), e.freq);
                    if (!e.err)
                        check(cpsr[0] == 1'b0, "R10", "cpsr even", longint'(cpsr), longint'(e.cpsr));
                end
            end
            prev_done = done;
        end
    end

    // Driver: pushes the expectation, pulses start, waits for the result.
    task automatic run(input longint rate, input longint tgt, input string tag,
                       input bit poke_busy, output int cycles);
        expq.push_back(model(rate, tgt));
        tagq.push_back(tag);
        @(negedge clk);
        in_rate  = RW'(rate);
        req_rate = RW'(tgt);
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        cycles = 1;
        while (expq.size() != 0 && cycles < 20000) begin
            if (poke_busy && cycles == 50) begin
                start = 1'b1; in_rate = 120; req_rate = 45;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        if (expq.size() != 0) begin
            check(0, tag, "watchdog: no done", cycles, 0);
            expq.delete();
            tagq.delete();
        end
        repeat (5) @(negedge clk);
        check(err == last_err && int'(cpsr) == last_cpsr && int'(scr) == last_scr
              && longint'(freq) == last_freq, "R7", "outputs held after done",
              longint'(freq), last_freq);
    endtask

    task automatic finish_all();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_all();
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        // R9: reset values
        check(done == 1'b0, "R9", "done", longint'(done), 0);
        check(err == 1'b0, "R9", "err", longint'(err), 0);
        check(cpsr == CW'(CMIN), "R9", "cpsr", longint'(cpsr), CMIN);
        check(scr == '0, "R9", "scr", longint'(scr), 0);
        check(freq == '0, "R9", "freq", longint'(freq), 0);
        last_err = 0; last_cpsr = CMIN; last_scr = 0; last_freq = 0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: exact hit on the very first pair ends early
        run(1000000, 500000, "R5", 0, cyc);
        check(cyc < 150, "R5", "early exit cycles", cyc, 150);
        // R2: out of range above and below
        run(1000000, 600000, "R2", 0, cyc);
        run(1000000, 12499, "R2", 0, cyc);
        // R3: exact hit only at the last pair of the order
        run(1000000, 12500, "R3", 0, cyc);
        check(cyc > 1000, "R3", "full order visited", cyc, 1000);
        // R1: exact quotient inside the first prescaler row
        run(1000000, 100000, "R1", 0, cyc);
        // R6: closest match, no exact hit
        run(1000000, 30000, "R6", 0, cyc);
        run(12345677, 777777, "R6", 0, cyc);
        // R4: tie between 60 and 30 for request 45 keeps the earlier pair
        run(120, 45, "R4", 0, cyc);
        // R10: odd input rate, closest match
        run(1000003, 33333, "R10", 0, cyc);
        // R8: start pulsed mid-search is dropped
        run(1000000, 30000, "R8", 1, cyc);
        repeat (100) @(negedge clk);
        check(expq.size() == 0 && done == 1'b0, "R8", "no extra result", longint'(done), 0);
        check(longint'(freq) == model(1000000, 30000).freq, "R8", "result kept",
              longint'(freq), model(1000000, 30000).freq);
        finish_all();
    end
endmodule